// File: doc/BRIEF.md
# Configuration Register Slice with Base Address Window

This block is a small configuration register slice with a single byte-enabled read/write port. It holds two registers. The first is a 32-bit base address register that claims a naturally aligned memory window of `2**WIN_LOG2` bytes. With the default value, the window is 512 KB. Only the address bits above the window size can be written. All lower bits read back as zero, so software can learn the window size by writing ones and reading the value back. The block compares an incoming 32-bit address against the stored base and raises a registered hit signal when the window is enabled.

The second register is a 16-bit subsystem vendor identifier. Software may write it once after reset. The first write cycle that enables either of its byte lanes stores the enabled bytes and locks the whole register. After that, only a reset clears the value and allows a new write. Reads return data one cycle after the request. A read of an unmapped offset returns zero.

Addressing is by 32-bit word. The two low bits of the request offset are ignored, and byte lane n carries data bits 8n+7:8n.

Top module: `cfg_bar_slice`

## Requirements
- R1: After a synchronous reset, the base register reads 00000000h, the vendor ID register reads 00000000h, `win_hit` is 0 and `rd_valid` is 0.
- R2: A write to word offset 14h (`BAR_OFFS`) updates bits 31:19 of the base register from `req_wdata`.
- R3: Bits 18:0 of the base register always read as zero and ignore writes. This covers the size field 18:4, prefetchable bit 3, memory type bits 2:1 = 00 (32-bit) and memory-space bit 0.
- R4: On a base register write, only the writable bits inside lanes whose `req_be` bit is set change. Bits in disabled lanes keep their value.
- R5: The vendor ID occupies bits 15:0 (lanes 0 and 1) of word offset 2Ch (`VID_OFFS`). Bits 31:16 of that word read as zero.
- R6: The first write cycle with `req_be[0]` or `req_be[1]` set stores the enabled vendor ID bytes and locks the register. A disabled lane keeps its value, and every later write leaves the register unchanged.
- R7: A write to the vendor ID word with `req_be[1:0]` = 00 changes nothing and does not lock the register.
- R8: Only reset clears the vendor ID and re-arms it, so that the next write is accepted.
- R9: `win_hit` is registered. In the cycle after `probe_addr` and `mem_en` are presented, it is 1 exactly when `mem_en` is 1 and `probe_addr[31:19]` equals base bits 31:19.
- R10: A read request gives `rd_valid` = 1 with its data in the next cycle. Reads of unmapped offsets return zero. Write requests give no `rd_valid`, and `rd_data` is zero when `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the access; bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane write enables |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| mem_en | input | 1 | Enables the window decode |
| probe_addr | input | 32 | Address checked against the window |
| win_hit | output | 1 | Registered window hit |

## Verification
The bench uses the defaults: `WIN_LOG2` = 19, `ADDR_W` = 8, base register at 14h and vendor ID at 2Ch. These values give a 13-bit writable base field that spans lanes 2 and 3 and splits lane 2 between writable and hardwired bits. A partial-lane write therefore shows both the lane masking and the hardwired zeros in one read. The 8-bit offset space makes it cheap to read every other word as unmapped. Random probe addresses are biased toward the stored base, so hits, misses caused by a single differing bit, and hits blocked by `mem_en` all occur. Mid-run resets then re-arm the write-once register.

// File: rtl/cfg_bar_pkg.sv
package cfg_bar_pkg;
  localparam int CFG_DW = 32;
  localparam int CFG_BE = CFG_DW / 8;

  typedef struct packed {
    logic              wr;
    logic [CFG_DW-1:0] data;
    logic [CFG_BE-1:0] be;
  } cfg_wr_t;
endpackage

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg
  import cfg_bar_pkg::*;
#(
  parameter int WIN_LOG2 = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  cfg_wr_t           wr,
  input  logic              mem_en,
  input  logic [CFG_DW-1:0] probe_addr,
  output logic [CFG_DW-1:0] bar_word,
  output logic              win_hit
);
  localparam int BASE_W = CFG_DW - WIN_LOG2;

  logic [CFG_DW-1:WIN_LOG2] base_q;

  for (genvar b = WIN_LOG2; b < CFG_DW; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) base_q[b] <= 1'b0;
      else if (wr.wr && wr.be[b/8]) base_q[b] <= wr.data[b];
    end
  end

  assign bar_word = {base_q, {WIN_LOG2{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) win_hit <= 1'b0;
    else win_hit <= mem_en && (probe_addr[CFG_DW-1:WIN_LOG2] == base_q);
  end

  assert_lane_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wr.wr && !wr.be[3]) |=> $stable(bar_word[31:24]));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr.wr |=> $stable(bar_word));
  assert_hit_gate_R9: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> $past(mem_en));

  logic [BASE_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/cfg_vid_reg.sv
module cfg_vid_reg
  import cfg_bar_pkg::*;
#(
  parameter int VID_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cfg_wr_t          wr,
  output logic [VID_W-1:0] vid_q,
  output logic             locked
);
  localparam int VID_LANES = VID_W / 8;

  logic take;
  assign take = wr.wr && (|wr.be[VID_LANES-1:0]) && !locked;

  for (genvar l = 0; l < VID_LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) vid_q[8*l +: 8] <= 8'h00;
      else if (take && wr.be[l]) vid_q[8*l +: 8] <= wr.data[8*l +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) locked <= 1'b0;
    else if (take) locked <= 1'b1;
  end

  assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(vid_q));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
  assert_no_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (!locked && !(wr.wr && (|wr.be[VID_LANES-1:0]))) |=> !locked);
endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port
  import cfg_bar_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              sel_bar,
  input  logic              sel_vid,
  input  logic [CFG_DW-1:0] bar_word,
  input  logic [CFG_DW-1:0] vid_word,
  output logic              rd_valid,
  output logic [CFG_DW-1:0] rd_data
);
  logic [CFG_DW-1:0] mux_d;

  always_comb begin
    mux_d = '0;
    if (sel_bar) mux_d = bar_word;
    else if (sel_vid) mux_d = vid_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? mux_d : '0;
    end
  end

  assert_rd_lat_R10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  assert_rd_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!rd_valid && rd_data == '0));
endmodule

// File: rtl/cfg_bar_slice.sv
module cfg_bar_slice
  import cfg_bar_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              WIN_LOG2 = 19,
  parameter int              VID_W    = 16,
  parameter logic [ADDR_W-1:0] BAR_OFFS = 8'h14,
  parameter logic [ADDR_W-1:0] VID_OFFS = 8'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CFG_DW-1:0] req_wdata,
  input  logic [CFG_BE-1:0] req_be,
  output logic              rd_valid,
  output logic [CFG_DW-1:0] rd_data,
  input  logic              mem_en,
  input  logic [CFG_DW-1:0] probe_addr,
  output logic              win_hit
);
  localparam int WORD_W = ADDR_W - 2;

  logic sel_bar, sel_vid;
  assign sel_bar = req_addr[ADDR_W-1:2] == BAR_OFFS[ADDR_W-1:2];
  assign sel_vid = req_addr[ADDR_W-1:2] == VID_OFFS[ADDR_W-1:2];

  cfg_wr_t bar_wr, vid_wr;
  always_comb begin
    bar_wr.wr   = req_valid && req_write && sel_bar;
    bar_wr.data = req_wdata;
    bar_wr.be   = req_be;
    vid_wr.wr   = req_valid && req_write && sel_vid;
    vid_wr.data = req_wdata;
    vid_wr.be   = req_be;
  end

  logic [CFG_DW-1:0] bar_word, vid_word;
  logic [VID_W-1:0]  vid_q;
  logic              vid_locked;

  cfg_bar_reg #(.WIN_LOG2(WIN_LOG2)) u_bar (
    .clk(clk), .rst(rst), .wr(bar_wr), .mem_en(mem_en),
    .probe_addr(probe_addr), .bar_word(bar_word), .win_hit(win_hit)
  );

  cfg_vid_reg #(.VID_W(VID_W)) u_vid (
    .clk(clk), .rst(rst), .wr(vid_wr), .vid_q(vid_q), .locked(vid_locked)
  );

  assign vid_word = {{(CFG_DW-VID_W){1'b0}}, vid_q};

  cfg_rd_port u_rd (
    .clk(clk), .rst(rst), .rd_req(req_valid && !req_write),
    .sel_bar(sel_bar), .sel_vid(sel_vid),
    .bar_word(bar_word), .vid_word(vid_word),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assert_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && sel_bar) |=> rd_data[WIN_LOG2-1:0] == '0);
  assert_vid_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && sel_vid) |=> rd_data[CFG_DW-1:VID_W] == '0);

  logic [WORD_W-1:0] unused_word;
  assign unused_word = '0;
endmodule

// File: tb/cfg_bar_slice_tb.sv
module cfg_bar_slice_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rd_valid, win_hit;
  logic [31:0] rd_data;
  logic        mem_en = 1'b0;
  logic [31:0] probe_addr = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [12:0] m_base;
  logic [15:0] m_vid;
  bit          m_lock;

  always #5 clk = ~clk;

  cfg_bar_slice u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_en(mem_en),
    .probe_addr(probe_addr), .win_hit(win_hit)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a[7:2] == 6'h05) return {m_base, 19'h0};
    if (a[7:2] == 6'h0B) return {16'h0, m_vid};
    return 32'h0;
  endfunction

  function automatic bit exp_hit(input logic [31:0] p, input bit en);
    return en && (p[31:19] == m_base);
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    if (a[7:2] == 6'h05) begin
      for (int b = 19; b < 32; b++)
        if (be[b/8]) m_base[b-19] = d[b];
    end else if (a[7:2] == 6'h0B && !m_lock && (be[0] || be[1])) begin
      if (be[0]) m_vid[7:0] = d[7:0];
      if (be[1]) m_vid[15:8] = d[15:8];
      m_lock = 1;
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk); #1;
    chk(rd_valid == 0, "R10 write gives no rd_valid", {31'h0, rd_valid}, 32'h0);
    model_write(a, d, be);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    logic [31:0] e;
    e = exp_read(a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = $urandom; req_be = 4'hF;
    @(posedge clk); #1;
    chk(rd_valid == 1, {tag, " rd_valid (R10)"}, {31'h0, rd_valid}, 32'h1);
    chk(rd_data == e, tag, rd_data, e);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_probe(input logic [31:0] p, input bit en, input string tag);
    bit e;
    e = exp_hit(p, en);
    @(negedge clk);
    probe_addr = p; mem_en = en;
    @(posedge clk); #1;
    chk(win_hit == e, tag, {31'h0, win_hit}, {31'h0, e});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    chk(rd_valid == 0 && win_hit == 0, "R1 outputs in reset", {30'h0, rd_valid, win_hit}, 32'h0);
    @(negedge clk); rst = 0;
    m_base = '0; m_vid = '0; m_lock = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_base = '0; m_vid = '0; m_lock = 0;
    repeat (2) @(posedge clk);
    do_reset();
    // R1 reset state
    do_read(8'h14, "R1 base after reset");
    do_read(8'h2C, "R1 vid after reset");
    do_probe(32'h0000_1234, 0, "R1 win_hit low after reset");
    // R2 R3 all-ones probe of window size
    do_write(8'h14, 32'hFFFF_FFFF, 4'hF);
    do_read(8'h14, "R3 size probe reads FFF80000");
    chk(exp_read(8'h14) == 32'hFFF8_0000, "R2 model base", exp_read(8'h14), 32'hFFF8_0000);
    // R4 lane masking: only lane 2 enabled
    do_write(8'h14, 32'h0000_0000, 4'b0100);
    do_read(8'h17, "R4 lane2 only write");
    do_write(8'h14, 32'h1200_0000, 4'b1011);
    do_read(8'h14, "R4 lane3 write keeps lane2");
    // R9 window hits
    do_probe({m_base, 19'h7FFFF}, 1, "R9 hit top of window");
    do_probe({m_base, 19'h0}, 0, "R9 mem_en low blocks hit");
    do_probe({m_base ^ 13'h1, 19'h0}, 1, "R9 miss one bit off");
    // R10 unmapped
    do_read(8'h10, "R10 unmapped 10h");
    do_read(8'h30, "R10 unmapped 30h");
    do_read(8'hFC, "R10 unmapped FCh");
    // R7 no-lane write does not lock
    do_write(8'h2C, 32'h0000_BEEF, 4'b1100);
    do_read(8'h2C, "R7 upper-lane vid write ignored");
    // R6 single-lane write locks
    do_write(8'h2C, 32'hFFFF_AB5A, 4'b0001);
    do_read(8'h2C, "R6 lane0 write, lane1 kept");
    do_write(8'h2D, 32'h0000_7777, 4'b0011);
    do_read(8'h2C, "R6 second write ignored");
    do_read(8'h2E, "R5 upper half zero");
    // R8 reset re-arms
    do_reset();
    do_read(8'h2C, "R8 vid cleared by reset");
    do_write(8'h2C, 32'h0000_C0DE, 4'b0011);
    do_read(8'h2C, "R8 rearmed write taken");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] a;
      op = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: a = 8'h14 | 8'($urandom_range(0, 3));
        1: a = 8'h2C | 8'($urandom_range(0, 3));
        default: a = 8'($urandom);
      endcase
      if (op < 3) do_write(a, $urandom, 4'($urandom));
      else if (op < 7) do_read(a, "R2 R5 random read");
      else if (op < 9) do_probe(($urandom_range(0, 1) != 0) ? {m_base, 19'($urandom)} : $urandom,
                                 $urandom_range(0, 3) != 0, "R9 random probe");
      else do_reset();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule